// File: doc/BRIEF.md
# Six-State Instruction Sequencer

This block is the timing and control heart of a small accumulator machine. A one-hot ring of six timing steps advances on every clock edge. For each step the block produces a 12-bit word of register-transfer strobes for the datapath. Steps one to three are the same for every instruction. They drive the program counter onto the bus and load the address register, then advance the program counter, then move the addressed memory word into the instruction register. Steps four to six depend on the 4-bit opcode held in the instruction register.

Five instructions are decoded: load accumulator, add, subtract, output and halt. A halt seen in step four freezes the ring and raises a sticky halt flag. From then on the block emits only the inactive word until reset. The ring position and the halt flag are registered. The control word is decoded from the registered ring and the live opcode. This lets a word loaded into the instruction register at the end of step three steer step four.

Top module: `ctl_sequencer`

## Requirements
- R1: While `rst` is high at a rising edge, the next cycle shows `t_state` = 6'b000001 (step one), `halted` low and the step-one control word.
- R2: `t_state` is one-hot, with bit k-1 marking step k. Without halt it advances one step per clock and wraps from step six back to step one.
- R3: The control word bits, from bit 11 down to bit 0, are: pc_inc, pc_drive, mar_load_n, mem_drive_n, ir_load_n, ir_drive_n, acc_load_n, acc_drive, alu_sub, alu_drive, breg_load_n, out_load_n. The inactive word is 12'h3E3. At most one bus driver (pc_drive, mem_drive_n low, ir_drive_n low, acc_drive, alu_drive) is active in any cycle.
- R4: Steps one, two and three emit 12'h5E3, 12'hBE3 and 12'h263 whatever the opcode is, even when the opcode is the halt code.
- R5: Opcode 4'b0000 (load accumulator) emits 12'h1A3, 12'h2C3 and 12'h3E3 in steps four to six.
- R6: Opcode 4'b0001 (add) emits 12'h1A3, 12'h2E1 and 12'h3C7 in steps four to six.
- R7: Opcode 4'b0010 (subtract) emits 12'h1A3, 12'h2E1 and 12'h3CF in steps four to six. alu_sub is only ever set together with alu_drive.
- R8: Opcode 4'b1110 (output) emits 12'h3F2, 12'h3E3 and 12'h3E3 in steps four to six.
- R9: Opcode 4'b1111 (halt) in step four emits 12'h3E3. From the next cycle `halted` is high and `t_state` stays at step four. The word stays 12'h3E3 whatever the opcode does, until reset.
- R10: Any other opcode emits 12'h3E3 in steps four to six and the ring keeps advancing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 4 | Upper nibble of the instruction register |
| ctl_word | output | 12 | Register-transfer strobes for the current step |
| t_state | output | 6 | One-hot current timing step |
| halted | output | 1 | Sticky halt flag |

## Verification
The assertions assume that `rst` is a clean synchronous level, high at the first clock edge. They also assume that the opcode is a defined 4-bit value at each rising edge. They do not assume that the opcode is constant within an instruction. The stimulus changes the opcode only shortly after a rising edge and starts with reset held. It deliberately drives the halt code and other unrelated values during the fetch steps and while halted, so that both the opcode-blind steps and the frozen state are exercised.

// File: rtl/ctl_pkg.sv
package ctl_pkg;
  localparam int CW_W  = 12;
  localparam int OPC_W = 4;

  typedef struct packed {
    logic pc_inc;
    logic pc_drive;
    logic mar_load_n;
    logic mem_drive_n;
    logic ir_load_n;
    logic ir_drive_n;
    logic acc_load_n;
    logic acc_drive;
    logic alu_sub;
    logic alu_drive;
    logic breg_load_n;
    logic out_load_n;
  } ctl_word_t;

  localparam ctl_word_t CW_IDLE = ctl_word_t'(12'h3E3);

  localparam logic [OPC_W-1:0] OPC_LOAD = 4'b0000;
  localparam logic [OPC_W-1:0] OPC_ADD  = 4'b0001;
  localparam logic [OPC_W-1:0] OPC_SUB  = 4'b0010;
  localparam logic [OPC_W-1:0] OPC_OUT  = 4'b1110;
  localparam logic [OPC_W-1:0] OPC_HALT = 4'b1111;

  // step is zero-based: 0..2 fetch, 3..5 execute
  function automatic ctl_word_t step_word(input int step, input logic [OPC_W-1:0] opc);
    ctl_word_t w;
    w = CW_IDLE;
    case (step)
      0: begin w.pc_drive = 1'b1; w.mar_load_n = 1'b0; end
      1: w.pc_inc = 1'b1;
      2: begin w.mem_drive_n = 1'b0; w.ir_load_n = 1'b0; end
      3: begin
        if (opc == OPC_LOAD || opc == OPC_ADD || opc == OPC_SUB) begin
          w.ir_drive_n = 1'b0; w.mar_load_n = 1'b0;
        end else if (opc == OPC_OUT) begin
          w.acc_drive = 1'b1; w.out_load_n = 1'b0;
        end
      end
      4: begin
        if (opc == OPC_LOAD) begin
          w.mem_drive_n = 1'b0; w.acc_load_n = 1'b0;
        end else if (opc == OPC_ADD || opc == OPC_SUB) begin
          w.mem_drive_n = 1'b0; w.breg_load_n = 1'b0;
        end
      end
      5: begin
        if (opc == OPC_ADD || opc == OPC_SUB) begin
          w.alu_drive = 1'b1; w.acc_load_n = 1'b0;
          w.alu_sub = (opc == OPC_SUB);
        end
      end
      default: w = CW_IDLE;
    endcase
    return w;
  endfunction
endpackage

// File: rtl/ctl_ring.sv
module ctl_ring #(
  parameter int T_COUNT   = 6,
  parameter int HALT_STEP = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               hlt_req,
  output logic [T_COUNT-1:0] ring,
  output logic               halted
);
  localparam logic [T_COUNT-1:0] RING_INIT = T_COUNT'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      ring   <= RING_INIT;
      halted <= 1'b0;
    end else if (!halted) begin
      if (ring[HALT_STEP-1] && hlt_req) begin
        halted <= 1'b1;
      end else begin
        ring <= {ring[T_COUNT-2:0], ring[T_COUNT-1]};
      end
    end
  end

  AST_RESET_T1: assert property (@(posedge clk) rst |=> (ring == RING_INIT && !halted)); // R1
  AST_RING_ONEHOT: assert property (@(posedge clk) disable iff (rst) $onehot(ring)); // R2
  AST_RING_WRAP: assert property (@(posedge clk) disable iff (rst) (ring[T_COUNT-1] && !halted) |=> ring[0]); // R2
  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (rst) halted |=> halted); // R9
  AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (rst) halted |=> $stable(ring)); // R9
  AST_HALT_AT_STEP: assert property (@(posedge clk) disable iff (rst) $rose(halted) |-> ring[HALT_STEP-1]); // R9
endmodule

// File: rtl/ctl_decode.sv
module ctl_decode
  import ctl_pkg::*;
#(
  parameter int T_COUNT = 6
) (
  input  logic [T_COUNT-1:0] ring,
  input  logic [OPC_W-1:0]   opcode,
  input  logic               halted,
  output ctl_word_t          cw
);
  logic [CW_W-1:0] delta [T_COUNT];
  logic [CW_W-1:0] merged;

  // one-hot AND-OR mux over differences from the idle word
  for (genvar k = 0; k < T_COUNT; k++) begin : g_step
    assign delta[k] = ring[k] ? (step_word(k, opcode) ^ CW_IDLE) : '0;
  end

  always_comb begin
    merged = '0;
    for (int k = 0; k < T_COUNT; k++) merged = merged | delta[k];
    cw = halted ? CW_IDLE : ctl_word_t'(merged ^ CW_IDLE);
  end
endmodule

// File: rtl/ctl_sequencer.sv
module ctl_sequencer
  import ctl_pkg::*;
#(
  parameter int T_COUNT   = 6,
  parameter int HALT_STEP = 4,
  parameter int OP_W      = OPC_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [OP_W-1:0]    opcode,
  output logic [CW_W-1:0]    ctl_word,
  output logic [T_COUNT-1:0] t_state,
  output logic               halted
);
  logic [T_COUNT-1:0] ring;
  logic               halt_q;
  ctl_word_t          cw;

  ctl_ring #(.T_COUNT(T_COUNT), .HALT_STEP(HALT_STEP)) u_ring (
    .clk    (clk),
    .rst    (rst),
    .hlt_req(opcode == OPC_HALT),
    .ring   (ring),
    .halted (halt_q)
  );

  ctl_decode #(.T_COUNT(T_COUNT)) u_decode (
    .ring  (ring),
    .opcode(opcode),
    .halted(halt_q),
    .cw    (cw)
  );

  assign ctl_word = cw;
  assign t_state  = ring;
  assign halted   = halt_q;

  AST_ONE_BUS_DRIVER: assert property (@(posedge clk) disable iff (rst)
    $countones({cw.pc_drive, !cw.mem_drive_n, !cw.ir_drive_n, cw.acc_drive, cw.alu_drive}) <= 1); // R3
  AST_SUB_NEEDS_ALU: assert property (@(posedge clk) disable iff (rst) cw.alu_sub |-> cw.alu_drive); // R7
  AST_HALT_QUIET: assert property (@(posedge clk) disable iff (rst) halt_q |-> (cw == CW_IDLE)); // R9
  AST_FETCH_LOADS_IR: assert property (@(posedge clk) disable iff (rst) !cw.ir_load_n |-> ring[2]); // R4
endmodule

// File: tb/test_ctl_sequencer.sv
module test_ctl_sequencer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  opcode = 4'b0000;
  logic [11:0] ctl_word;
  logic [5:0]  t_state;
  logic        halted;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench model
  int step = 1;
  bit hmodel = 0;

  logic [5:0]  q_st [$];
  logic [11:0] q_cw [$];
  logic        q_h  [$];
  string       q_tag [$];

  always #5 clk = ~clk;

  ctl_sequencer i_ctl_sequencer (
    .clk(clk), .rst(rst), .opcode(opcode),
    .ctl_word(ctl_word), .t_state(t_state), .halted(halted)
  );

  function automatic logic [11:0] exp_word(int s, logic [3:0] op, bit h);
    if (h) return 12'h3E3;
    case (s)
      1: return 12'h5E3;
      2: return 12'hBE3;
      3: return 12'h263;
      4: case (op)
           4'b0000, 4'b0001, 4'b0010: return 12'h1A3;
           4'b1110: return 12'h3F2;
           default: return 12'h3E3;
         endcase
      5: case (op)
           4'b0000: return 12'h2C3;
           4'b0001, 4'b0010: return 12'h2E1;
           default: return 12'h3E3;
         endcase
      6: case (op)
           4'b0001: return 12'h3C7;
           4'b0010: return 12'h3CF;
           default: return 12'h3E3;
         endcase
      default: return 12'h3E3;
    endcase
  endfunction

  function automatic string tag_of(int s, logic [3:0] op, bit h, bit r);
    if (r) return "R1";
    if (h) return "R9";
    if (s <= 3) return "R4 R2";
    case (op)
      4'b0000: return "R5 R2";
      4'b0001: return "R6 R2";
      4'b0010: return "R7 R2";
      4'b1110: return "R8 R3";
      4'b1111: return "R9";
      default: return "R10 R3";
    endcase
  endfunction

  bit prev_rst = 1;

  task automatic cycle(input logic [3:0] op, input bit r);
    @(posedge clk);
    #2;
    opcode = op;
    rst = r;
    q_st.push_back(6'(1) << (step - 1));
    q_cw.push_back(exp_word(step, op, hmodel));
    q_h.push_back(hmodel);
    q_tag.push_back(tag_of(step, op, hmodel, prev_rst));
    prev_rst = r;
    if (r) begin
      step = 1; hmodel = 0;
    end else if (!hmodel) begin
      if (step == 4 && op == 4'b1111) hmodel = 1;
      else step = (step % 6) + 1;
    end
  endtask

  task automatic instr(input logic [3:0] fetch_op, input logic [3:0] op);
    for (int i = 0; i < 3; i++) cycle(fetch_op, 1'b0);
    for (int i = 0; i < 3; i++) cycle(op, 1'b0);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #4;
      if (q_st.size() > 0) begin
        logic [5:0] es; logic [11:0] ec; logic eh; string t;
        es = q_st.pop_front(); ec = q_cw.pop_front();
        eh = q_h.pop_front();  t  = q_tag.pop_front();
        checks++;
        if (t_state !== es || ctl_word !== ec || halted !== eh) begin
          errors++;
          $display("FAIL %s: actual st=%b cw=%h h=%b expected st=%b cw=%h h=%b",
                   t, t_state, ctl_word, halted, es, ec, eh);
        end
      end
    end
  end

  // driver
  initial begin
    for (int i = 0; i < 3; i++) cycle(4'b0110, 1'b1);   // R1 reset held
    cycle(4'b0000, 1'b0);
    cycle(4'b0000, 1'b0);
    cycle(4'b0000, 1'b0);
    for (int i = 0; i < 3; i++) cycle(4'b0000, 1'b0);    // R5 load
    instr(4'b1111, 4'b0001);                            // R4 halt code in fetch, R6 add
    instr(4'b0101, 4'b0010);                            // R7 subtract
    instr(4'b0010, 4'b1110);                            // R8 output
    instr(4'b1110, 4'b0101);                            // R10 unknown opcode
    instr(4'b0001, 4'b0000);                            // R2 wrap again
    for (int i = 0; i < 3; i++) cycle(4'b0000, 1'b0);
    cycle(4'b1111, 1'b0);                               // R9 halt in step four
    for (int i = 0; i < 8; i++) cycle(4'(i * 3), 1'b0); // R9 opcode ignored while halted
    cycle(4'b0000, 1'b1);                               // R1 reset out of halt
    cycle(4'b0000, 1'b0);
    cycle(4'b0000, 1'b0);
    for (int i = 0; i < 3; i++) cycle(4'b0001, 1'b0);
    for (int i = 0; i < 3; i++) cycle(4'b0001, 1'b0);   // R6 after reset
    @(posedge clk);
    #6;
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // watchdog
  initial begin
    #200000;
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule